// File: doc/BRIEF.md
# Timer Channel Output Compare Generator

This block is one channel of a timer's output-compare stage. An external counter supplies its value and count direction each cycle. The channel compares that value against an active compare register and produces a registered reference level. A 4-bit mode field selects how the reference reacts. The choices are:

- hold the reference;
- set, clear or toggle it on a match;
- force it low or high;
- run one of two complementary pulse-width rules;
- run a retriggerable one-pulse rule that waits for a trigger strobe.

A combined reference is built from this channel's reference and a partner channel's reference. In the combined modes it is the OR or the AND of the two. In the asymmetric modes it takes this channel's reference while counting up and the partner's reference while counting down.

The compare value is double-buffered. A write always lands in a shadow register. With preload off, the write also reaches the active register at once. With preload on, the active register takes the shadow value only on an update strobe.

The main and complementary pin outputs apply their own polarity bits to the reference. A channel-enable input parks both pins at their inactive level.

Top module: `oc_channel`

## Requirements
- R1: After reset the reference is 0, the active and shadow compare values are 0 and the one-pulse rule is disarmed.
- R2: In mode 0000 the reference keeps its value whatever the counter does. The reserved codes 1010 and 1011 behave the same way.
- R3: On a clock edge where the counter equals the active compare value, mode 0001 sets the reference to 1, mode 0010 clears it to 0 and mode 0011 inverts it. On any other edge these modes keep the reference.
- R4: Mode 0100 drives the reference to 0 and mode 0101 drives it to 1 on every edge, whatever the compare result.
- R5: Mode 0110 makes the reference 1 when counter < compare while counting up (`dir_down_i`=0), and when counter <= compare while counting down; otherwise the reference is 0. Mode 0111 gives the inverse level in both directions.
- R6: Modes 1000 and 1001 hold an idle level until a trigger strobe arms them. The idle level is 1 for 1000 counting up, 0 for 1000 counting down, 0 for 1001 counting up and 1 for 1001 counting down. Once armed, 1000 follows the 0110 rule and 1001 follows the 0111 rule, both from the trigger edge onward. An update strobe disarms them on its own edge. A trigger on the same edge as an update wins. Any other mode disarms.
- R7: Mode 1100 uses the 0110 rule and drives the combined output with the OR of this reference and the partner reference. Mode 1101 uses the 0111 rule and drives the AND of the two. In all non-combined, non-asymmetric modes the combined output equals the reference.
- R8: Modes 1110 and 1111 use the 0110 and 0111 rules respectively. The combined output is this reference while counting up and the partner reference while counting down.
- R9: With preload on, a compare write changes only the shadow value. The active value takes the shadow value on the edge of an update strobe.
- R10: With preload off, a compare write changes the active value on that edge, and an update strobe leaves the active value unchanged.
- R11: While enabled, the main output is the reference XOR `pol_i` and the complementary output is the inverted reference XOR `pol_n_i`. The reference itself stays active high.
- R12: While `ch_en_i` is 0, the main output equals `pol_i` and the complementary output equals `pol_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Counter value |
| dir_down_i | input | 1 | Count direction, 1 = down |
| mode_i | input | 4 | Compare mode code |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_data_i | input | CNT_W | Compare value to write |
| preload_en_i | input | 1 | Route writes through the shadow register |
| update_i | input | 1 | Update event strobe |
| trig_i | input | 1 | One-pulse trigger strobe |
| partner_ref_i | input | 1 | Partner channel reference |
| ch_en_i | input | 1 | Output enable |
| pol_i | input | 1 | Main output polarity, 1 = active low |
| pol_n_i | input | 1 | Complementary output polarity, 1 = active low |
| ref_o | output | 1 | Registered reference level |
| ref_comb_o | output | 1 | Combined or asymmetric reference |
| oc_o | output | 1 | Main output |
| ocn_o | output | 1 | Complementary output |

## Verification
On every cycle the assertions check the following:

- the forced levels one edge after a force mode;
- that the reference holds in the frozen mode;
- that the OR and AND combinations are consistent with the reference;
- that the pins park while disabled;
- that the two pins stay opposite under equal polarity.

The compare-dependent behaviour needs the bench's sweeps: the pulse-width rules in both directions, including the equality case that differs between up and down counting, and the match modes. The same holds for preload versus immediate loading, and for one-pulse arming, retriggering and disarming on update. The bench steps every compare value against every counter value for each pulse-width mode.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
  typedef enum logic [3:0] {
    OCM_FROZEN  = 4'b0000,
    OCM_SET     = 4'b0001,
    OCM_CLR     = 4'b0010,
    OCM_TOG     = 4'b0011,
    OCM_LO      = 4'b0100,
    OCM_HI      = 4'b0101,
    OCM_PWM_A   = 4'b0110,
    OCM_PWM_B   = 4'b0111,
    OCM_OPP_A   = 4'b1000,
    OCM_OPP_B   = 4'b1001,
    OCM_RSV_A   = 4'b1010,
    OCM_RSV_B   = 4'b1011,
    OCM_CMB_OR  = 4'b1100,
    OCM_CMB_AND = 4'b1101,
    OCM_ASY_A   = 4'b1110,
    OCM_ASY_B   = 4'b1111
  } oc_mode_e;
endpackage

// File: rtl/oc_cmp_reg.sv
`timescale 1ns/1ps
module oc_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             preload_i,
  input  logic             update_i,
  output logic [CNT_W-1:0] cmp_o
);
  logic [CNT_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_i) shadow_q <= data_i;
      if (!preload_i && wr_i)        active_q <= data_i;
      else if (preload_i && update_i) active_q <= shadow_q;
    end
  end

  assign cmp_o = active_q;
endmodule

// File: rtl/oc_ref_gen.sv
`timescale 1ns/1ps
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             down_i,
  input  logic             trig_i,
  input  logic             update_i,
  output logic             ref_o
);
  oc_mode_e mode;
  logic ref_q, ref_d, armed_q, armed_d;
  logic match, pwm_a, one_pulse, idle_lvl;

  assign mode      = oc_mode_e'(mode_i);
  assign match     = (cnt_i == cmp_i);
  // equality counts as active only when counting down
  assign pwm_a     = down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);
  assign one_pulse = (mode == OCM_OPP_A) || (mode == OCM_OPP_B);
  assign idle_lvl  = (mode_i[0] == down_i);

  always_comb begin
    if (!one_pulse)    armed_d = 1'b0;
    else if (trig_i)   armed_d = 1'b1;
    else if (update_i) armed_d = 1'b0;
    else               armed_d = armed_q;
  end

  always_comb begin
    unique case (mode)
      OCM_SET:                           ref_d = match ? 1'b1 : ref_q;
      OCM_CLR:                           ref_d = match ? 1'b0 : ref_q;
      OCM_TOG:                           ref_d = ref_q ^ match;
      OCM_LO:                            ref_d = 1'b0;
      OCM_HI:                            ref_d = 1'b1;
      OCM_PWM_A, OCM_CMB_OR, OCM_ASY_A:  ref_d = pwm_a;
      OCM_PWM_B, OCM_CMB_AND, OCM_ASY_B: ref_d = ~pwm_a;
      OCM_OPP_A:                         ref_d = armed_d ? pwm_a : idle_lvl;
      OCM_OPP_B:                         ref_d = armed_d ? ~pwm_a : idle_lvl;
      default:                           ref_d = ref_q; // frozen and reserved
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ref_q   <= ref_d;
      armed_q <= armed_d;
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/oc_out_stage.sv
`timescale 1ns/1ps
module oc_out_stage
  import oc_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic       ref_i,
  input  logic       partner_i,
  input  logic       down_i,
  input  logic       en_i,
  input  logic       pol_i,
  input  logic       pol_n_i,
  output logic       comb_o,
  output logic       oc_o,
  output logic       ocn_o
);
  oc_mode_e mode;
  assign mode = oc_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      OCM_CMB_OR:           comb_o = ref_i | partner_i;
      OCM_CMB_AND:          comb_o = ref_i & partner_i;
      OCM_ASY_A, OCM_ASY_B: comb_o = down_i ? partner_i : ref_i;
      default:              comb_o = ref_i;
    endcase
  end

  assign oc_o  = en_i ? (ref_i ^ pol_i)    : pol_i;
  assign ocn_o = en_i ? (~ref_i ^ pol_n_i) : pol_n_i;
endmodule

// File: rtl/oc_channel.sv
`timescale 1ns/1ps
module oc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_down_i,
  input  logic [3:0]       mode_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             preload_en_i,
  input  logic             update_i,
  input  logic             trig_i,
  input  logic             partner_ref_i,
  input  logic             ch_en_i,
  input  logic             pol_i,
  input  logic             pol_n_i,
  output logic             ref_o,
  output logic             ref_comb_o,
  output logic             oc_o,
  output logic             ocn_o
);
  logic [CNT_W-1:0] cmp_act;

  oc_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cmp_wr_i),
    .data_i    (cmp_data_i),
    .preload_i (preload_en_i),
    .update_i  (update_i),
    .cmp_o     (cmp_act)
  );

  oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .cnt_i    (cnt_i),
    .cmp_i    (cmp_act),
    .down_i   (dir_down_i),
    .trig_i   (trig_i),
    .update_i (update_i),
    .ref_o    (ref_o)
  );

  oc_out_stage u_out (
    .mode_i    (mode_i),
    .ref_i     (ref_o),
    .partner_i (partner_ref_i),
    .down_i    (dir_down_i),
    .en_i      (ch_en_i),
    .pol_i     (pol_i),
    .pol_n_i   (pol_n_i),
    .comb_o    (ref_comb_o),
    .oc_o      (oc_o),
    .ocn_o     (ocn_o)
  );
endmodule

// File: rtl/oc_channel_chk.sv
`timescale 1ns/1ps
module oc_channel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] mode_i,
  input logic       ch_en_i,
  input logic       pol_i,
  input logic       pol_n_i,
  input logic       ref_o,
  input logic       ref_comb_o,
  input logic       oc_o,
  input logic       ocn_o
);
  a_r4_force_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0101) |=> ref_o);

  a_r4_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0100) |=> !ref_o);

  a_r2_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0000) |=> $stable(ref_o));

  a_r7_or_covers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b1100 && ref_o) |-> ref_comb_o);

  a_r7_and_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b1101 && !ref_o) |-> !ref_comb_o);

  a_r12_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_en_i |-> (oc_o == pol_i && ocn_o == pol_n_i));

  a_r11_opposite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_en_i && pol_i == pol_n_i) |-> (oc_o != ocn_o));
endmodule

bind oc_channel oc_channel_chk u_chk (.*);

// File: tb/oc_channel_bench.sv
`timescale 1ns/1ps
module oc_channel_bench;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni, dir, wr, pre, upd, trig, partner, en, pol, pol_n;
  logic [W-1:0] cnt, data;
  logic [3:0] mode;
  logic ref_o, comb_o, oc_o, ocn_o;

  oc_channel #(.CNT_W(W)) u_oc_channel (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_i(cnt), .dir_down_i(dir), .mode_i(mode),
    .cmp_wr_i(wr), .cmp_data_i(data), .preload_en_i(pre), .update_i(upd),
    .trig_i(trig), .partner_ref_i(partner), .ch_en_i(en), .pol_i(pol),
    .pol_n_i(pol_n), .ref_o(ref_o), .ref_comb_o(comb_o), .oc_o(oc_o), .ocn_o(ocn_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic m_ref = 0, m_armed = 0;
  logic [W-1:0] m_act = '0, m_sh = '0;

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0b exp=%0b mode=%0d cnt=%0d dir=%0b", tag, act, exp, mode, cnt, dir);
    end
  endtask

  task automatic model_edge();
    logic match, pa, opm, an, idle, nr;
    logic [W-1:0] na;
    match = (cnt == m_act);
    pa    = dir ? (cnt <= m_act) : (cnt < m_act);
    opm   = (mode == 4'd8) || (mode == 4'd9);
    an    = !opm ? 1'b0 : trig ? 1'b1 : upd ? 1'b0 : m_armed;
    idle  = (mode[0] == dir);
    case (mode)
      4'd1: nr = match ? 1'b1 : m_ref;
      4'd2: nr = match ? 1'b0 : m_ref;
      4'd3: nr = m_ref ^ match;
      4'd4: nr = 1'b0;
      4'd5: nr = 1'b1;
      4'd6, 4'd12, 4'd14: nr = pa;
      4'd7, 4'd13, 4'd15: nr = !pa;
      4'd8: nr = an ? pa : idle;
      4'd9: nr = an ? !pa : idle;
      default: nr = m_ref;
    endcase
    na = m_act;
    if (!pre && wr) na = data;
    else if (pre && upd) na = m_sh;
    if (wr) m_sh = data;
    m_act = na; m_ref = nr; m_armed = an;
  endtask

  function automatic logic exp_comb();
    case (mode)
      4'd12: return m_ref | partner;
      4'd13: return m_ref & partner;
      4'd14, 4'd15: return dir ? partner : m_ref;
      default: return m_ref;
    endcase
  endfunction

  task automatic check_outs(string tag);
    chk(tag, ref_o, m_ref);
    chk(tag, comb_o, exp_comb());
    if (en) begin
      chk("R11", oc_o, m_ref ^ pol);
      chk("R11", ocn_o, !m_ref ^ pol_n);
    end else begin
      chk("R12", oc_o, pol);
      chk("R12", ocn_o, pol_n);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outs(tag);
  endtask

  task automatic wr_cmp(logic [W-1:0] v, string tag);
    wr = 1'b1; data = v;
    step(tag);
    wr = 1'b0;
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < N; k++) begin
      cnt = W'(k); partner = k[1];
      step(tag);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int pm[6];
    pm = '{6, 7, 12, 13, 14, 15};
    rst_ni = 0; dir = 0; wr = 0; pre = 0; upd = 0; trig = 0; partner = 0;
    en = 1; pol = 0; pol_n = 0; cnt = '0; data = '0; mode = 4'd0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: reset state
    check_outs("R1");
    mode = 4'd6; cnt = '0;
    step("R1"); // active compare 0: 0 < 0 false
    mode = 4'd6; dir = 1; cnt = '0;
    step("R1"); // 0 <= 0 true while counting down

    // R5, R7, R8: full compare x counter sweep, both directions
    for (int i = 0; i < 6; i++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < N; c++) begin
          string tg;
          tg = (i < 2) ? "R5" : (i < 4) ? "R7" : "R8";
          mode = 4'(pm[i]); dir = d[0]; cnt = '0;
          wr_cmp(W'(c), "R10");
          sweep(tg);
        end

    // R3: match modes
    dir = 0;
    wr_cmp(W'(5), "R10");
    for (int m = 1; m < 4; m++) begin
      mode = 4'(m);
      sweep("R3");
      sweep("R3");
    end

    // R4: forced levels
    mode = 4'd5; step("R4"); step("R4");
    mode = 4'd4; step("R4"); step("R4");

    // R2: frozen and reserved hold
    mode = 4'd5; step("R4");
    mode = 4'd0;  sweep("R2");
    mode = 4'd10; sweep("R2");
    mode = 4'd4;  step("R4");
    mode = 4'd11; sweep("R2");
    mode = 4'd0;  sweep("R2");

    // R6: retriggerable one-pulse
    wr_cmp(W'(7), "R10");
    for (int m = 8; m < 10; m++)
      for (int d = 0; d < 2; d++) begin
        mode = 4'(m); dir = d[0];
        sweep("R6");
        trig = 1; cnt = W'(2); step("R6"); trig = 0;
        sweep("R6");
        upd = 1; step("R6"); upd = 0;
        sweep("R6");
        trig = 1; upd = 1; step("R6"); trig = 0; upd = 0;
        sweep("R6");
        mode = 4'd6; step("R6");
        mode = 4'(m); sweep("R6");
      end

    // R9: preload path
    mode = 4'd6; dir = 0; pre = 0;
    wr_cmp(W'(3), "R10");
    pre = 1;
    wr_cmp(W'(12), "R9");
    sweep("R9");
    upd = 1; step("R9"); upd = 0;
    sweep("R9");

    // R10: immediate path; update ignored
    pre = 0;
    wr_cmp(W'(9), "R10");
    sweep("R10");
    pre = 1; wr_cmp(W'(2), "R9"); pre = 0;
    upd = 1; step("R10"); upd = 0;
    sweep("R10");

    // R11, R12: polarity and enable
    for (int f = 4; f < 6; f++)
      for (int e = 0; e < 2; e++)
        for (int p = 0; p < 4; p++) begin
          mode = 4'(f); en = e[0]; pol = p[0]; pol_n = p[1];
          step(e ? "R11" : "R12");
        end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule